// File: doc/BRIEF.md
# Periodic Battery Health Monitor

This block decides when the backup battery of a battery-backed memory is checked, and it holds the result of the last check. A check starts each time the main supply becomes nominal. After that, further checks run at a fixed interval for as long as the supply stays nominal. The interval is counted in ticks of a slow timebase, and its default equals one day of one-second ticks. While the memory runs on its battery, no check is scheduled.

Each check waits a settle window of a fixed number of timebase ticks. It then samples a digital comparator flag that reports whether the battery is below its low threshold, nominally 2.5 V. The sampled value drives the battery-low output, which holds until a later check passes. The status register records the kind of check behind the latest failure. A failure at power-up marks the memory contents as suspect. A failure on a periodic check only warns that the battery is near the end of its life. If the supply drops while a check is still settling, the check is abandoned and the stored result stays as it was.

Top module: `batt_health_mon`

## Requirements
- R1: While rst_ni is low, and right after it is released, batt_low_o is 0 and all status_o bits are 0.
- R2: On the first clock edge at which supply_ok_i is high after having been low (or after reset), a check starts, and status_o[2] (busy) reads 1 from the next cycle.
- R3: batt_low_o does not change before the SETTLE_TICKS-th tick_i pulse after a check starts.
- R4: At the clock edge of the SETTLE_TICKS-th tick of a check, batt_low_o takes the value of batt_below_i (1 = battery below threshold), and busy returns to 0.
- R5: A failing power-up check sets status_o[0] (data suspect) to 1 and status_o[1] to 0.
- R6: The interval counter restarts at every power-up. The first periodic check starts on the INTERVAL_TICKS-th tick after the power-up edge, and later ones start INTERVAL_TICKS ticks after the previous periodic start.
- R7: A failing periodic check sets status_o[1] (near end of life) to 1 and status_o[0] to 0.
- R8: A passing check clears batt_low_o, status_o[0] and status_o[1].
- R9: While supply_ok_i is low, no check runs: busy is 0 one cycle after supply_ok_i is seen low, and ticks start nothing.
- R10: If supply_ok_i drops during a check, the check ends without changing batt_low_o or status_o[1:0].
- R11: Values of batt_below_i before the final tick of the settle window have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase tick, one-cycle pulse |
| supply_ok_i | input | 1 | Main supply nominal |
| batt_below_i | input | 1 | Comparator flag, 1 = battery below threshold |
| batt_low_o | output | 1 | Latched battery-low result |
| status_o | output | 3 | [0] data suspect, [1] near end of life, [2] check busy |

## Verification
A table of power-up checks pairs mid-window comparator values with end-of-window values. This separates a design that samples at the end of the window from one that samples early or ORs samples together, and it shows that a pass clears an earlier failure. Periodic checks are counted tick by tick around the expiry of the interval. A power cycle partway through an interval shows whether the count restarts. A supply drop mid-check, and ticks given while the supply is low, separate a true abort and idle from a result that leaks through.

// File: rtl/bhm_pkg.sv
package bhm_pkg;
  typedef enum logic {
    CHK_PWRUP    = 1'b0,
    CHK_PERIODIC = 1'b1
  } chk_kind_e;

  typedef struct packed {
    logic busy;
    logic near_eol;
    logic data_suspect;
  } bhm_status_t;
endpackage

// File: rtl/bhm_power_detect.sv
module bhm_power_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  output logic pwr_up_o
);
  logic supply_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) supply_q <= 1'b0;
    else         supply_q <= supply_ok_i;
  end

  assign pwr_up_o = supply_ok_i & ~supply_q;
endmodule

// File: rtl/bhm_interval_timer.sv
module bhm_interval_timer #(
  parameter int unsigned INTERVAL_TICKS = 86400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic supply_ok_i,
  input  logic pwr_up_i,
  output logic periodic_o
);
  localparam int unsigned CNT_W = (INTERVAL_TICKS > 1) ? $clog2(INTERVAL_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             expire;

  assign expire     = tick_i & (cnt_q == LAST);
  assign periodic_o = supply_ok_i & ~pwr_up_i & expire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (pwr_up_i || !supply_ok_i) cnt_q <= '0;
    else if (expire)               cnt_q <= '0;
    else if (tick_i)               cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bhm_check_seq.sv
module bhm_check_seq
  import bhm_pkg::*;
#(
  parameter int unsigned SETTLE_TICKS = 4
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      supply_ok_i,
  input  logic      pwr_up_i,
  input  logic      periodic_i,
  output logic      busy_o,
  output logic      done_o,
  output chk_kind_e kind_o
);
  logic busy_q;
  logic last_tick;

  // settle counter only exists when the window spans more than one tick
  generate
    if (SETTLE_TICKS > 1) begin : g_settle_cnt
      localparam int unsigned SW = $clog2(SETTLE_TICKS);
      localparam logic [SW-1:0] SLAST = SW'(SETTLE_TICKS - 1);
      logic [SW-1:0] cnt_q;
      assign last_tick = (cnt_q == SLAST);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                             cnt_q <= '0;
        else if (!supply_ok_i || pwr_up_i)       cnt_q <= '0;
        else if (periodic_i && !busy_q)          cnt_q <= '0;
        else if (busy_q && tick_i && !last_tick) cnt_q <= cnt_q + 1'b1;
      end
    end else begin : g_settle_one
      assign last_tick = 1'b1;
    end
  endgenerate

  assign done_o = busy_q & tick_i & supply_ok_i & last_tick & ~pwr_up_i;
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      kind_o <= CHK_PWRUP;
    end else if (!supply_ok_i) begin
      busy_q <= 1'b0;                 // abort, result untouched
    end else if (pwr_up_i) begin
      busy_q <= 1'b1;
      kind_o <= CHK_PWRUP;
    end else if (periodic_i && !busy_q) begin
      busy_q <= 1'b1;
      kind_o <= CHK_PERIODIC;
    end else if (done_o) begin
      busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/batt_health_mon.sv
module batt_health_mon
  import bhm_pkg::*;
#(
  parameter int unsigned INTERVAL_TICKS = 86400,
  parameter int unsigned SETTLE_TICKS   = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       supply_ok_i,
  input  logic       batt_below_i,
  output logic       batt_low_o,
  output logic [2:0] status_o
);
  logic        pwr_up;
  logic        periodic;
  logic        busy;
  logic        done;
  chk_kind_e   kind;
  logic        low_q, suspect_q, eol_q;
  bhm_status_t st;

  bhm_power_detect u_pwr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .supply_ok_i(supply_ok_i),
    .pwr_up_o   (pwr_up)
  );

  bhm_interval_timer #(.INTERVAL_TICKS(INTERVAL_TICKS)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .supply_ok_i(supply_ok_i),
    .pwr_up_i   (pwr_up),
    .periodic_o (periodic)
  );

  bhm_check_seq #(.SETTLE_TICKS(SETTLE_TICKS)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .supply_ok_i(supply_ok_i),
    .pwr_up_i   (pwr_up),
    .periodic_i (periodic),
    .busy_o     (busy),
    .done_o     (done),
    .kind_o     (kind)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q     <= 1'b0;
      suspect_q <= 1'b0;
      eol_q     <= 1'b0;
    end else if (done) begin
      low_q     <= batt_below_i;
      suspect_q <= batt_below_i & (kind == CHK_PWRUP);
      eol_q     <= batt_below_i & (kind == CHK_PERIODIC);
    end
  end

  always_comb begin
    st.busy         = busy;
    st.near_eol     = eol_q;
    st.data_suspect = suspect_q;
  end

  assign batt_low_o = low_q;
  assign status_o   = st;
endmodule

// File: rtl/batt_health_mon_chk.sv
module batt_health_mon_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       supply_ok_i,
  input logic       batt_low_o,
  input logic [2:0] status_o
);
  assert_start_on_pwrup_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(supply_ok_i) |=> status_o[2]);

  assert_low_moves_at_end_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(batt_low_o) |-> $past(status_o[2] && tick_i && supply_ok_i));

  assert_one_cause_R5_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(status_o[1:0]));

  assert_cause_needs_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[0] || status_o[1]) |-> batt_low_o);

  assert_idle_on_backup_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> !status_o[2]);

  assert_abort_keeps_result_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> ($stable(batt_low_o) && $stable(status_o[1:0])));
endmodule

bind batt_health_mon batt_health_mon_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .supply_ok_i(supply_ok_i),
  .batt_low_o (batt_low_o),
  .status_o   (status_o)
);

// File: tb/tb_batt_health_mon.sv
`timescale 1ns/1ps
module tb_batt_health_mon;
  localparam int unsigned INTERVAL = 12;
  localparam int unsigned SETTLE   = 3;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       supply_ok_i = 1'b0;
  logic       batt_below_i = 1'b0;
  logic       batt_low_o;
  logic [2:0] status_o;

  int total = 0;
  int bad   = 0;

  always #2.5 clk_i = ~clk_i;

  batt_health_mon #(.INTERVAL_TICKS(INTERVAL), .SETTLE_TICKS(SETTLE)) dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .supply_ok_i (supply_ok_i),
    .batt_below_i(batt_below_i),
    .batt_low_o  (batt_low_o),
    .status_o    (status_o)
  );

  // {mid value, end value, expected low, expected status[1:0]}
  localparam logic [4:0] VEC [5] = '{
    5'b0_1_1_01,
    5'b1_0_0_00,
    5'b0_0_0_00,
    5'b1_1_1_01,
    5'b0_0_0_00
  };

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic do_tick(input logic below);
    tick_i = 1'b1; batt_below_i = below; step();
    tick_i = 1'b0; step();
  endtask

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic power_cycle();
    supply_ok_i = 1'b0; step(); step();
    supply_ok_i = 1'b1; step();
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic prev_low;
    logic seen;
    step(); step();
    check("R1 reset", {batt_low_o, status_o}, 4'h0);
    rst_ni = 1'b1; step();
    check("R1 after release", {batt_low_o, status_o}, 4'h0);

    // R9: ticks while on backup start nothing
    seen = 1'b0;
    for (int i = 0; i < 20; i++) begin
      do_tick(1'b1);
      seen |= status_o[2];
    end
    check("R9 no check on backup", {3'b0, seen | batt_low_o}, 4'h0);

    // vector table of power-up checks: R2 R3 R4 R5 R8 R11
    prev_low = 1'b0;
    for (int v = 0; v < 5; v++) begin
      power_cycle();
      check("R2 busy after power-up", {3'b0, status_o[2]}, 4'h1);
      for (int k = 0; k < int'(SETTLE) - 1; k++) do_tick(VEC[v][4]);
      check("R3 no early result", {3'b0, batt_low_o}, {3'b0, prev_low});
      do_tick(VEC[v][3]);
      check("R4 R11 result low", {3'b0, batt_low_o}, {3'b0, VEC[v][2]});
      check("R5 R8 status", {1'b0, status_o}, {2'b0, VEC[v][1:0]});
      prev_low = VEC[v][2];
    end

    // R6: first periodic check one full interval after power-up
    for (int k = 0; k < int'(INTERVAL - SETTLE) - 1; k++) do_tick(1'b0);
    check("R6 not yet periodic", {3'b0, status_o[2]}, 4'h0);
    do_tick(1'b0);
    check("R6 periodic start", {3'b0, status_o[2]}, 4'h1);
    for (int k = 0; k < int'(SETTLE); k++) do_tick(1'b1);
    check("R7 periodic fail", {batt_low_o, status_o}, 4'b1_010);

    // R6: interval restarts at power-up
    for (int k = 0; k < 5; k++) do_tick(1'b0);
    power_cycle();
    for (int k = 0; k < int'(SETTLE); k++) do_tick(1'b0);
    check("R8 pass clears periodic fail", {batt_low_o, status_o}, 4'h0);
    seen = 1'b0;
    for (int k = 0; k < int'(INTERVAL - SETTLE) - 1; k++) begin
      do_tick(1'b0);
      seen |= status_o[2];
    end
    check("R6 counter restarted", {3'b0, seen}, 4'h0);
    do_tick(1'b0);
    check("R6 periodic after restart", {3'b0, status_o[2]}, 4'h1);
    for (int k = 0; k < int'(SETTLE); k++) do_tick(1'b0);
    check("R4 periodic pass", {batt_low_o, status_o}, 4'h0);

    // R10: abort mid-check keeps prior failing result
    power_cycle();
    for (int k = 0; k < int'(SETTLE); k++) do_tick(1'b1);
    check("R5 setup fail", {batt_low_o, status_o}, 4'b1_001);
    power_cycle();
    do_tick(1'b0);
    supply_ok_i = 1'b0; batt_below_i = 1'b0; step();
    check("R10 abort busy clear", {3'b0, status_o[2]}, 4'h0);
    for (int k = 0; k < int'(SETTLE); k++) do_tick(1'b0);
    check("R10 result kept", {batt_low_o, status_o}, 4'b1_001);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule